// File: doc/BRIEF.md
# ADC Sample and Conversion Sequencer

This block is the digital control around a 12-bit converter core. It builds a converter clock enable by picking one of four source tick inputs and dividing it by 1 to 8. On a trigger it opens a sample window. In pulse mode an internal timer sets the window length. In extended mode the window tracks the synchronised trigger level. When the window closes, the block holds the input sample and counts a fixed conversion of thirteen converter ticks. It then writes a 12-bit result. That result is clamped to programmable lower and upper limits and scaled linearly between them.

The configuration fields are held in registers. They take a new value only while conversions are disabled. A master power bit stops all sampling and conversion activity. Everything runs on one system clock. The converter clock is a one-cycle enable (`tick`), so every interval below is counted in converter ticks.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset, `sample_win`, `busy` and `done` are 0 and `result` is 0x000.
- R2: In pulse mode (`cfg_pulse_mode`=1), a rising edge of the synchronised trigger opens a window of exactly 4·2^n converter ticks, where n is `cfg_sample_sel`.
- R3: In extended mode (`cfg_pulse_mode`=0), the window opens on the synchronised trigger rise and closes when the synchronised trigger falls. Its length equals the time the trigger was high. The two-stage synchroniser adds the same delay to both edges.
- R4: The fall of `sample_win` starts a conversion. `done` rises exactly 13 converter ticks later, for one system clock, together with the new `result`. `busy` is high from the window opening until that same edge.
- R5: The converter tick rate is the rate of `src_tick[cfg_clk_sel]` divided by `cfg_div`+1.
- R6: If the held sample is at or above `lim_hi`, the result is 0xFFF. This check takes priority over the lower limit.
- R7: If the held sample is at or below `lim_lo` and below `lim_hi`, the result is 0x000.
- R8: Between the limits, the result is floor((sample − lim_lo)·4095 / (lim_hi − lim_lo)).
- R9: `sample_in` is captured on the tick that closes the window. Later changes do not affect the result.
- R10: `cfg_wr` updates the configuration only while `conv_en`=0. While `conv_en`=1 it is ignored.
- R11: No window opens while `conv_en`=0.
- R12: With `power_on`=0 no window opens. Dropping `power_on` aborts any sample or conversion on the next clock, and no `done` follows.
- R13: A trigger that arrives while `busy` is high is ignored: no second window opens and no extra `done` is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick | input | 4 | Candidate converter clock source enables |
| power_on | input | 1 | Master enable of the sequencer |
| conv_en | input | 1 | Conversion enable; also locks configuration |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_pulse_mode | input | 1 | 1 = timer-defined window, 0 = window follows trigger |
| cfg_sample_sel | input | 3 | Pulse window length code n (4·2^n ticks) |
| cfg_clk_sel | input | 2 | Index of the source tick used |
| cfg_div | input | 3 | Divider code, divides by value+1 |
| trig | input | 1 | Asynchronous sample trigger |
| sample_in | input | 12 | Digital stand-in for the analog input |
| lim_lo | input | 12 | Lower conversion limit |
| lim_hi | input | 12 | Upper conversion limit |
| sample_win | output | 1 | Sample window, high while sampling |
| busy | output | 1 | Sampling or conversion in progress |
| done | output | 1 | One-cycle pulse with a new result |
| result | output | 12 | Latest conversion result |

## Verification
A trigger arrival and a conversion in progress can meet in the same cycle, and so can a configuration write and an enabled sequencer. Both are provoked on purpose. A trigger pulse is sent during a conversion, and the bench then watches that no second window opens and that the scoreboard receives no `done` it did not expect. A configuration write is also issued with `conv_en` high, and the next window length then shows that the old mode and length still apply. A further case changes `sample_in` after the window closes but before `done`, to show that the held sample is the one converted.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_CONV   = 2'd2
  } seq_state_t;

  localparam int CONV_TICKS = 13;
  localparam int WIN_BASE   = 4;

  typedef struct packed {
    logic       pulse_mode;
    logic [2:0] sample_sel;
    logic [1:0] clk_sel;
    logic [2:0] div;
  } seq_cfg_t;
endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen #(
  parameter int NSRC = 4,
  parameter int SELW = 2,
  parameter int DIVW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_tick,
  input  logic [SELW-1:0] sel,
  input  logic [DIVW-1:0] div,
  output logic            tick
);
  logic [DIVW-1:0] dcnt;
  logic            src;

  assign src = src_tick[sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      dcnt <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (src) begin
        if (dcnt >= div) begin
          dcnt <= '0;
          tick <= 1'b1;
        end else begin
          dcnt <= dcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic trig,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain[0] <= 1'b0;
    end else if (tick) begin
      chain[0] <= trig;
    end
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        chain[i] <= 1'b0;
      end else if (tick) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= 1'b0;
    end else if (tick) begin
      prev <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/adc_scale.sv
module adc_scale #(
  parameter int W = 12
) (
  input  logic [W-1:0] smp,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic [W-1:0] code
);
  localparam logic [W-1:0] FULL = {W{1'b1}};

  logic [2*W-1:0] num;
  logic [2*W-1:0] den;
  logic [2*W-1:0] quo;

  always_comb begin
    num = {{W{1'b0}}, smp - lo} * {{W{1'b0}}, FULL};
    den = {{W{1'b0}}, hi - lo};
    quo = (den == '0) ? '0 : num / den;
    if (smp >= hi) begin
      code = FULL;
    end else if (smp <= lo) begin
      code = '0;
    end else begin
      code = quo[W-1:0];
    end
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int W    = 12,
  parameter int SSW  = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic           power_on,
  input  logic           conv_en,
  input  logic           pulse_mode,
  input  logic [SSW-1:0] sample_sel,
  input  logic           trig_level,
  input  logic           trig_rise,
  input  logic [W-1:0]   sample_in,
  input  logic [W-1:0]   scaled,
  output logic [W-1:0]   held,
  output logic           sample_win,
  output logic           busy,
  output logic           done,
  output logic [W-1:0]   result
);
  localparam int WIN_MAX = WIN_BASE << ((1 << SSW) - 1);
  localparam int CW      = $clog2(WIN_MAX);
  localparam int KW      = $clog2(CONV_TICKS);

  seq_state_t    state;
  logic [CW-1:0] wcnt;
  logic [KW-1:0] ccnt;
  logic [CW:0]   win_len;
  logic          close_win;

  assign win_len   = (CW+1)'(WIN_BASE) << sample_sel;
  assign close_win = pulse_mode ? (wcnt == '0) : ~trig_level;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      wcnt       <= '0;
      ccnt       <= '0;
      held       <= '0;
      sample_win <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
      result     <= '0;
    end else begin
      done <= 1'b0;
      if (!power_on) begin
        state      <= ST_IDLE;
        sample_win <= 1'b0;
        busy       <= 1'b0;
      end else if (tick) begin
        case (state)
          ST_IDLE: begin
            if (conv_en && trig_rise) begin
              state      <= ST_SAMPLE;
              sample_win <= 1'b1;
              busy       <= 1'b1;
              wcnt       <= CW'(win_len - 1'b1);
            end
          end
          ST_SAMPLE: begin
            if (close_win) begin
              state      <= ST_CONV;
              sample_win <= 1'b0;
              held       <= sample_in;
              ccnt       <= '0;
            end else if (pulse_mode) begin
              wcnt <= wcnt - 1'b1;
            end
          end
          ST_CONV: begin
            if (ccnt == KW'(CONV_TICKS - 1)) begin
              state  <= ST_IDLE;
              busy   <= 1'b0;
              done   <= 1'b1;
              result <= scaled;
            end else begin
              ccnt <= ccnt + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int W    = 12,
  parameter int NSRC = 4,
  parameter int SYNC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  src_tick,
  input  logic             power_on,
  input  logic             conv_en,
  input  logic             cfg_wr,
  input  logic             cfg_pulse_mode,
  input  logic [2:0]       cfg_sample_sel,
  input  logic [1:0]       cfg_clk_sel,
  input  logic [2:0]       cfg_div,
  input  logic             trig,
  input  logic [W-1:0]     sample_in,
  input  logic [W-1:0]     lim_lo,
  input  logic [W-1:0]     lim_hi,
  output logic             sample_win,
  output logic             busy,
  output logic             done,
  output logic [W-1:0]     result
);
  seq_cfg_t     cfg;
  logic         tick;
  logic         trig_level;
  logic         trig_rise;
  logic [W-1:0] held;
  logic [W-1:0] scaled;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '{pulse_mode: 1'b1, sample_sel: 3'd0, clk_sel: 2'd0, div: 3'd0};
    end else if (cfg_wr && !conv_en) begin
      cfg <= '{pulse_mode: cfg_pulse_mode, sample_sel: cfg_sample_sel,
               clk_sel: cfg_clk_sel, div: cfg_div};
    end
  end

  adc_tick_gen #(.NSRC(NSRC), .SELW(2), .DIVW(3)) u_tick (
    .clk(clk), .rst(rst), .src_tick(src_tick),
    .sel(cfg.clk_sel), .div(cfg.div), .tick(tick)
  );

  adc_trig_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst(rst), .tick(tick), .trig(trig),
    .level(trig_level), .rise(trig_rise)
  );

  adc_scale #(.W(W)) u_scale (
    .smp(held), .lo(lim_lo), .hi(lim_hi), .code(scaled)
  );

  adc_seq_fsm #(.W(W), .SSW(3)) u_fsm (
    .clk(clk), .rst(rst), .tick(tick), .power_on(power_on),
    .conv_en(conv_en), .pulse_mode(cfg.pulse_mode),
    .sample_sel(cfg.sample_sel), .trig_level(trig_level),
    .trig_rise(trig_rise), .sample_in(sample_in), .scaled(scaled),
    .held(held), .sample_win(sample_win), .busy(busy), .done(done),
    .result(result)
  );
endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst,
  input logic         power_on,
  input logic         conv_en,
  input logic         sample_win,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] result
);
  p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_ends_busy_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  p_win_inside_busy_r4: assert property (@(posedge clk) disable iff (rst)
    sample_win |-> busy);

  p_fall_starts_conv_r4: assert property (@(posedge clk) disable iff (rst)
    ($fell(sample_win) && $past(power_on)) |-> busy);

  p_result_held_r9: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));

  p_start_needs_enable_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(conv_en) && $past(power_on)));

  p_power_off_idle_r12: assert property (@(posedge clk) disable iff (rst)
    !power_on |=> (!busy && !sample_win));
endmodule

bind adc_conv_seq adc_conv_seq_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .power_on(power_on), .conv_en(conv_en),
  .sample_win(sample_win), .busy(busy), .done(done), .result(result)
);

// File: tb/adc_conv_seq_test.sv
module adc_conv_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  src_tick = 4'b0001;
  logic        power_on = 1'b0;
  logic        conv_en = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_pulse_mode = 1'b1;
  logic [2:0]  cfg_sample_sel = 3'd0;
  logic [1:0]  cfg_clk_sel = 2'd0;
  logic [2:0]  cfg_div = 3'd0;
  logic        trig = 1'b0;
  logic [11:0] sample_in = 12'd0;
  logic [11:0] lim_lo = 12'd100;
  logic [11:0] lim_hi = 12'd4000;
  logic        sample_win, busy, done;
  logic [11:0] result;

  int n_run = 0;
  int n_fail = 0;
  int exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  adc_conv_seq uut (
    .clk(clk), .rst(rst), .src_tick(src_tick), .power_on(power_on),
    .conv_en(conv_en), .cfg_wr(cfg_wr), .cfg_pulse_mode(cfg_pulse_mode),
    .cfg_sample_sel(cfg_sample_sel), .cfg_clk_sel(cfg_clk_sel),
    .cfg_div(cfg_div), .trig(trig), .sample_in(sample_in),
    .lim_lo(lim_lo), .lim_hi(lim_hi), .sample_win(sample_win),
    .busy(busy), .done(done), .result(result)
  );

  // source 2 ticks every other clock, source 0 every clock
  always @(negedge clk) src_tick[2] <= ~src_tick[2];

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int ref_code(input int s);
    if (s >= int'(lim_hi)) return 4095;
    if (s <= int'(lim_lo)) return 0;
    return ((s - int'(lim_lo)) * 4095) / (int'(lim_hi) - int'(lim_lo));
  endfunction

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R13 unexpected done", int'(result), -1);
        end else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(int'(result) == e, t, int'(result), e);
        end
      end
    end
  end

  task automatic write_cfg(input bit pm, input int ss, input int cs, input int dv);
    @(negedge clk);
    cfg_pulse_mode = pm;
    cfg_sample_sel = 3'(ss);
    cfg_clk_sel    = 2'(cs);
    cfg_div        = 3'(dv);
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic run_conv(input int smp, input int trig_len, input int exp_win,
                          input int exp_conv, input int late_smp, input string tag);
    int wl = 0;
    int cl = 0;
    int to = 0;
    exp_q.push_back(ref_code(smp));
    tag_q.push_back(tag);
    @(negedge clk);
    sample_in = 12'(smp);
    fork
      begin
        trig = 1'b1;
        repeat (trig_len) @(negedge clk);
        trig = 1'b0;
      end
      begin
        while (!sample_win && to < 2000) begin @(negedge clk); to++; end
        while (sample_win) begin wl++; @(negedge clk); end
        if (late_smp >= 0) sample_in = 12'(late_smp);
        while (!done && cl < 5000) begin cl++; @(negedge clk); end
      end
    join
    check(wl == exp_win, {tag, " window length (R2/R3/R5)"}, wl, exp_win);
    check(cl == exp_conv, {tag, " conversion length (R4/R5)"}, cl, exp_conv);
    repeat (6) @(negedge clk);
  endtask

  task automatic expect_idle(input int cycles, input string tag);
    int seen = 0;
    repeat (cycles) begin
      @(negedge clk);
      if (busy || sample_win) seen++;
    end
    check(seen == 0, tag, seen, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(!sample_win && !busy && !done && result == 12'd0, "R1 reset state",
          int'({sample_win, busy, done}), 0);
    rst = 1'b0;
    power_on = 1'b1;
    repeat (2) @(negedge clk);

    write_cfg(1'b1, 0, 0, 0);
    conv_en = 1'b1;
    run_conv(2050, 3, 4, 13, -1, "R8 mid scale");
    run_conv(101, 3, 4, 13, -1, "R8 just above low");
    conv_en = 1'b0;
    write_cfg(1'b1, 2, 0, 0);
    conv_en = 1'b1;
    run_conv(4000, 3, 16, 13, -1, "R6 at upper limit");
    run_conv(4095, 3, 16, 13, -1, "R6 above upper limit");
    run_conv(100, 3, 16, 13, -1, "R7 at lower limit");
    run_conv(0, 3, 16, 13, -1, "R7 below lower limit");
    run_conv(1000, 3, 16, 13, 3000, "R9 held sample");

    conv_en = 1'b0;
    write_cfg(1'b1, 0, 0, 2);
    conv_en = 1'b1;
    run_conv(3000, 3, 12, 39, -1, "R5 divide by 3");
    conv_en = 1'b0;
    write_cfg(1'b1, 0, 2, 0);
    conv_en = 1'b1;
    run_conv(1500, 6, 8, 26, -1, "R5 source 2");
    conv_en = 1'b0;
    write_cfg(1'b1, 1, 2, 1);
    conv_en = 1'b1;
    run_conv(2500, 12, 32, 52, -1, "R5 source 2 divide by 2");

    conv_en = 1'b0;
    write_cfg(1'b0, 0, 0, 0);
    conv_en = 1'b1;
    run_conv(3999, 20, 20, 13, -1, "R3 extended 20");
    run_conv(200, 7, 7, 13, -1, "R3 extended 7");

    // R10: write while enabled must be ignored (stay extended mode)
    write_cfg(1'b1, 3, 0, 0);
    run_conv(777, 10, 10, 13, -1, "R10 config locked");

    // R11: disabled
    conv_en = 1'b0;
    write_cfg(1'b1, 0, 0, 0);
    @(negedge clk);
    trig = 1'b1;
    repeat (5) @(negedge clk);
    trig = 1'b0;
    expect_idle(40, "R11 no window when disabled");

    // R12: power off blocks start
    conv_en = 1'b1;
    power_on = 1'b0;
    trig = 1'b1;
    repeat (5) @(negedge clk);
    trig = 1'b0;
    expect_idle(40, "R12 no window when powered off");

    // R12: abort during sampling
    power_on = 1'b1;
    conv_en = 1'b0;
    write_cfg(1'b1, 5, 0, 0);
    conv_en = 1'b1;
    trig = 1'b1;
    repeat (4) @(negedge clk);
    trig = 1'b0;
    begin
      int to = 0;
      while (!sample_win && to < 100) begin @(negedge clk); to++; end
      check(sample_win == 1'b1, "R12 window opened before abort", int'(sample_win), 1);
    end
    repeat (5) @(negedge clk);
    power_on = 1'b0;
    repeat (2) @(negedge clk);
    check(!busy && !sample_win, "R12 abort clears busy", int'({busy, sample_win}), 0);
    power_on = 1'b1;
    expect_idle(200, "R12 no resume after abort");

    // R13: trigger during conversion ignored
    conv_en = 1'b0;
    write_cfg(1'b1, 0, 0, 0);
    conv_en = 1'b1;
    exp_q.push_back(ref_code(3333));
    tag_q.push_back("R13 first result");
    @(negedge clk);
    sample_in = 12'd3333;
    trig = 1'b1;
    repeat (3) @(negedge clk);
    trig = 1'b0;
    begin
      int to = 0;
      while (!sample_win && to < 100) begin @(negedge clk); to++; end
      while (sample_win) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    trig = 1'b1;
    repeat (3) @(negedge clk);
    trig = 1'b0;
    begin
      int to = 0;
      while (!done && to < 100) begin @(negedge clk); to++; end
    end
    expect_idle(40, "R13 no second window");

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R4 all results delivered", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule